// File: doc/BRIEF.md
# GPIO pin function multiplexer

This block sits between a bank of 108 general-purpose pads and the peripherals that share them. Each pin has a small configuration byte. The byte picks which source drives the pin: one of three peripheral functions, plain GPIO, or a fifth alternate function that only the lowest 16 pins have. The same byte also sets the GPIO direction, a polarity inversion that applies to both the pad output and the pad input, and a pull-up disable. Four configuration bytes are packed into each 32-bit word of a flat register space.

Software programs the block through a plain synchronous register port. Writes are always accepted. Reads are always accepted and return data one cycle later, with no back-pressure in either direction. A GPIO data register supplies the driven level in GPIO mode. A read-only input register returns every pad level after a two-flop synchroniser, with the per-pin inversion applied. The same synchronised, inverted levels go to the peripherals on `core_in`.

The pad outputs are combinational from the stored configuration and the peripheral inputs. A change in a peripheral's data or enable therefore reaches the pad in the same cycle.

Top module: `gpio_pinmux`

## Requirements
- R1: Pin 4k+j is held in bits [8j+7:8j] of the word at address k, for k = 0..26. Within a byte, bits 5:3 are the function select, bit 2 is direction, bit 1 is invert and bit 0 is pull-up disable. Bits 7:6 of each byte read as 0 whatever was written. A read with `reg_re` high returns the word on `reg_rdata` after the next rising edge. `reg_rdata` holds its value while `reg_re` is low.
- R2: After reset every byte reads 8'h18 (function 3, direction 0, invert 0, pull-up disable 0) and the GPIO data register reads 0. Every `pad_oe` is 0, every `pad_do` is 0 and every `pad_pu` is 1.
- R3: Function select 0, 1 or 2 drives `pad_do`/`pad_oe` of pin p from `fn_do`/`fn_oe` bit f*108+p, where f is the select value.
- R4: Function select 3 sets `pad_oe` to the direction bit (1 = output) and takes the data from bit p of the GPIO data register. That register is at word addresses 32..35, with pin p at address 32 + p/32, bit p%32.
- R5: Function select 4 on pins 0..15 drives the pin from `alt_do[p]`/`alt_oe[p]`. Select 4 on pins 16 and above, and selects 5..7 on any pin, force `pad_oe` to 0 and send only the invert bit to `pad_do`. The written select value still reads back unchanged.
- R6: With the invert bit set, `pad_do` is the complement of the selected source in every function, and `core_in` is the complement of the synchronised pad level.
- R7: `pad_pu` is the inverse of the pull-up disable bit, except on pins 9, 12, 106 and 107, where `pad_pu` is always 1.
- R8: `core_in[p]` equals `pad_in[p]` delayed by two rising edges, XOR the invert bit. The read-only words at addresses 40..43 return `core_in`, with pin p at address 40 + p/32, bit p%32.
- R9: A configuration or data write changes the pads from the rising edge on which `reg_we` is sampled high. Writes to the input words, or to any address outside 0..26 and 32..35, change nothing. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Write strobe, always accepted |
| reg_re | input | 1 | Read strobe, data on the next cycle |
| reg_addr | input | 6 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, held between reads |
| fn_do | input | 324 | Peripheral output data, function f of pin p at bit f*108+p |
| fn_oe | input | 324 | Peripheral output enable, same layout as fn_do |
| alt_do | input | 16 | Alternate-function data for pins 0..15 |
| alt_oe | input | 16 | Alternate-function output enable for pins 0..15 |
| pad_in | input | 108 | Raw pad input levels |
| core_in | output | 108 | Synchronised, inversion-applied pad levels |
| pad_do | output | 108 | Pad output data |
| pad_oe | output | 108 | Pad output enable |
| pad_pu | output | 108 | Pad pull-up enable |

## Verification
A corrupted configuration byte appears on the same pin's `pad_oe`, `pad_do` or `pad_pu` in the cycle right after the edge that stored it. This holds as long as the peripheral inputs differ between functions, so the bench keeps them distinct and compares all three pad vectors against a behavioural model on every cycle. Faults in the synchroniser or the inversion show on `core_in` two edges after a pad change, and one edge later on the input words. A fault in the read path shows on `reg_rdata` one edge after the read strobe.

// File: rtl/gpio_pinmux_pkg.sv
package gpio_pinmux_pkg;
  localparam logic [2:0] FS_GPIO = 3'd3;
  localparam logic [2:0] FS_ALT  = 3'd4;

  typedef struct packed {
    logic [2:0] fsel;
    logic       dir;
    logic       inv;
    logic       pud;
  } pin_cfg_t;

  localparam pin_cfg_t CFG_RESET = '{fsel: FS_GPIO, dir: 1'b0, inv: 1'b0, pud: 1'b0};

  function automatic logic [7:0] cfg_to_byte(input pin_cfg_t c);
    return {2'b00, c};
  endfunction

  function automatic pin_cfg_t byte_to_cfg(input logic [5:0] b);
    return pin_cfg_t'(b);
  endfunction
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 108
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/gpio_pin_slice.sv
module gpio_pin_slice
  import gpio_pinmux_pkg::*;
#(
  parameter bit HAS_ALT   = 1'b0,
  parameter bit PU_FORCED = 1'b0
) (
  input  pin_cfg_t   cfg,
  input  logic [2:0] per_do,
  input  logic [2:0] per_oe,
  input  logic       alt_do,
  input  logic       alt_oe,
  input  logic       gpio_do,
  output logic       pad_do,
  output logic       pad_oe,
  output logic       pad_pu
);
  logic src_do, src_oe;

  always_comb begin
    src_do = 1'b0;
    src_oe = 1'b0;
    case (cfg.fsel)
      3'd0, 3'd1, 3'd2: begin
        src_do = per_do[cfg.fsel];
        src_oe = per_oe[cfg.fsel];
      end
      FS_GPIO: begin
        src_do = gpio_do;
        src_oe = cfg.dir;
      end
      FS_ALT: begin
        if (HAS_ALT) begin
          src_do = alt_do;
          src_oe = alt_oe;
        end
      end
      default: begin
        src_do = 1'b0;
        src_oe = 1'b0;
      end
    endcase
  end

  assign pad_do = src_do ^ cfg.inv;
  assign pad_oe = src_oe;

  generate
    if (PU_FORCED) begin : g_pu_fixed
      assign pad_pu = 1'b1;
    end else begin : g_pu_prog
      assign pad_pu = ~cfg.pud;
    end
  endgenerate
endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_pinmux_pkg::*;
#(
  parameter int NUM_PINS  = 108,
  parameter int ADDR_W    = 6,
  parameter int DATA_BASE = 32,
  parameter int IN_BASE   = 40
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic                     re,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [31:0]              wdata,
  output logic [31:0]              rdata,
  input  logic [NUM_PINS-1:0]      in_val,
  output pin_cfg_t [NUM_PINS-1:0]  cfg_o,
  output logic [NUM_PINS-1:0]      gdata_o
);
  localparam int NCFG = (NUM_PINS + 3) / 4;

  pin_cfg_t [NUM_PINS-1:0] cfg_q;
  logic [NUM_PINS-1:0]     gdata_q;
  logic [31:0]             rd_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NUM_PINS; p++) cfg_q[p] <= CFG_RESET;
      gdata_q <= '0;
    end else if (we) begin
      for (int p = 0; p < NUM_PINS; p++) begin
        if (addr == ADDR_W'(p / 4))
          cfg_q[p] <= byte_to_cfg(wdata[8*(p%4) +: 6]);
        if (addr == ADDR_W'(DATA_BASE + p / 32))
          gdata_q[p] <= wdata[p%32];
      end
    end
  end

  always_comb begin
    rd_word = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      if (addr == ADDR_W'(p / 4))
        rd_word[8*(p%4) +: 8] = cfg_to_byte(cfg_q[p]);
      if (addr == ADDR_W'(DATA_BASE + p / 32))
        rd_word[p%32] = gdata_q[p];
      if (addr == ADDR_W'(IN_BASE + p / 32))
        rd_word[p%32] = in_val[p];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= rd_word;
  end

  assign cfg_o   = cfg_q;
  assign gdata_o = gdata_q;

  // R9: a configuration write lands in storage on the strobe edge
  a_r9_cfg_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr < ADDR_W'(NCFG)) |=>
      (cfg_q[4*int'($past(addr))] == byte_to_cfg($past(wdata[5:0]))));

  // R1: reserved bits of a configuration word never read back as 1
  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (re && addr < ADDR_W'(NCFG)) |=> ((rdata & 32'hC0C0C0C0) == 32'h0));

  // R1: reg_rdata only moves after a read strobe
  a_r1_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !re |=> $stable(rdata));
endmodule

// File: rtl/gpio_pinmux.sv
module gpio_pinmux
  import gpio_pinmux_pkg::*;
#(
  parameter int NUM_PINS  = 108,
  parameter int ALT_PINS  = 16,
  parameter int ADDR_W    = 6,
  parameter int DATA_BASE = 32,
  parameter int IN_BASE   = 40,
  parameter logic [NUM_PINS-1:0] PU_LOCK =
    (NUM_PINS'(1) << 9) | (NUM_PINS'(1) << 12) |
    (NUM_PINS'(1) << 106) | (NUM_PINS'(1) << 107)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_we,
  input  logic                  reg_re,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [31:0]           reg_wdata,
  output logic [31:0]           reg_rdata,
  input  logic [3*NUM_PINS-1:0] fn_do,
  input  logic [3*NUM_PINS-1:0] fn_oe,
  input  logic [ALT_PINS-1:0]   alt_do,
  input  logic [ALT_PINS-1:0]   alt_oe,
  input  logic [NUM_PINS-1:0]   pad_in,
  output logic [NUM_PINS-1:0]   core_in,
  output logic [NUM_PINS-1:0]   pad_do,
  output logic [NUM_PINS-1:0]   pad_oe,
  output logic [NUM_PINS-1:0]   pad_pu
);
  pin_cfg_t [NUM_PINS-1:0] cfg_w;
  logic [NUM_PINS-1:0]     gdata_w;
  logic [NUM_PINS-1:0]     sync_w;
  logic [NUM_PINS-1:0]     inv_w;

  gpio_cfg_regs #(
    .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .DATA_BASE(DATA_BASE), .IN_BASE(IN_BASE)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .re(reg_re), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .in_val(core_in),
    .cfg_o(cfg_w), .gdata_o(gdata_w)
  );

  gpio_in_sync #(.W(NUM_PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(sync_w)
  );

  assign core_in = sync_w ^ inv_w;

  genvar p;
  generate
    for (p = 0; p < NUM_PINS; p++) begin : g_pin
      logic a_do, a_oe;
      assign inv_w[p] = cfg_w[p].inv;
      if (p < ALT_PINS) begin : g_alt
        assign a_do = alt_do[p];
        assign a_oe = alt_oe[p];
      end else begin : g_noalt
        assign a_do = 1'b0;
        assign a_oe = 1'b0;
      end

      gpio_pin_slice #(.HAS_ALT(p < ALT_PINS), .PU_FORCED(PU_LOCK[p])) u_slice (
        .cfg(cfg_w[p]),
        .per_do({fn_do[2*NUM_PINS+p], fn_do[NUM_PINS+p], fn_do[p]}),
        .per_oe({fn_oe[2*NUM_PINS+p], fn_oe[NUM_PINS+p], fn_oe[p]}),
        .alt_do(a_do), .alt_oe(a_oe), .gpio_do(gdata_w[p]),
        .pad_do(pad_do[p]), .pad_oe(pad_oe[p]), .pad_pu(pad_pu[p])
      );

      // R5: an unsupported select never drives the pad
      a_r5_bad_sel_undriven: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg_w[p].fsel > FS_ALT) || (cfg_w[p].fsel == FS_ALT && p >= ALT_PINS))
          |-> !pad_oe[p]);

      if (PU_LOCK[p]) begin : g_lock_chk
        // R7: locked pins keep the pull-up whatever is written
        a_r7_locked_pullup: assert property (@(posedge clk) disable iff (!rst_n)
          pad_pu[p]);
      end
    end
  endgenerate

  // R2: all pads are inputs on the first edge after reset release
  a_r2_inputs_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pad_oe == '0));
endmodule

// File: tb/gpio_pinmux_bench.sv
module gpio_pinmux_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 108;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0, reg_re = 1'b0;
  logic [5:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3*NP-1:0] fn_do = '0, fn_oe = '0;
  logic [15:0] alt_do = '0, alt_oe = '0;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] core_in, pad_do, pad_oe, pad_pu;

  int n_chk = 0, n_fail = 0;
  bit run_cmp = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_pinmux u_gpio_pinmux (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fn_do(fn_do), .fn_oe(fn_oe),
    .alt_do(alt_do), .alt_oe(alt_oe), .pad_in(pad_in), .core_in(core_in),
    .pad_do(pad_do), .pad_oe(pad_oe), .pad_pu(pad_pu)
  );

  // ---------------- behavioural reference model ----------------
  logic [7:0]    m_cfg [NP];
  logic [NP-1:0] m_gd, m_s1, m_s2;
  logic [31:0]   m_rd;

  function automatic bit is_locked(input int p);
    return (p == 9) || (p == 12) || (p == 106) || (p == 107);
  endfunction

  function automatic logic [NP-1:0] inv_vec();
    logic [NP-1:0] v;
    for (int p = 0; p < NP; p++) v[p] = m_cfg[p][1];
    return v;
  endfunction

  function automatic void model_pads(output logic [NP-1:0] d, output logic [NP-1:0] o,
                                     output logic [NP-1:0] u);
    for (int p = 0; p < NP; p++) begin
      int fs;
      logic sd, so;
      fs = int'(m_cfg[p][5:3]);
      sd = 1'b0; so = 1'b0;
      if (fs < 3) begin
        sd = fn_do[fs*NP + p]; so = fn_oe[fs*NP + p];
      end else if (fs == 3) begin
        sd = m_gd[p]; so = m_cfg[p][2];
      end else if (fs == 4 && p < 16) begin
        sd = alt_do[p]; so = alt_oe[p];
      end
      d[p] = sd ^ m_cfg[p][1];
      o[p] = so;
      u[p] = !m_cfg[p][0] || is_locked(p);
    end
  endfunction

  function automatic logic [31:0] model_read(input int a);
    logic [31:0] w;
    logic [NP-1:0] iv;
    w = '0;
    iv = m_s2 ^ inv_vec();
    for (int p = 0; p < NP; p++) begin
      if (a == p / 4) w[8*(p%4) +: 8] = m_cfg[p];
      if (a == 32 + p / 32) w[p%32] = m_gd[p];
      if (a == 40 + p / 32) w[p%32] = iv[p];
    end
    return w;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NP; p++) m_cfg[p] = 8'h18;
      m_gd = '0; m_s1 = '0; m_s2 = '0; m_rd = '0;
    end else begin
      if (reg_re) m_rd = model_read(int'(reg_addr));
      if (reg_we) begin
        for (int p = 0; p < NP; p++) begin
          if (int'(reg_addr) == p / 4) m_cfg[p] = reg_wdata[8*(p%4) +: 8] & 8'h3F;
          if (int'(reg_addr) == 32 + p / 32) m_gd[p] = reg_wdata[p%32];
        end
      end
      m_s2 = m_s1;
      m_s1 = pad_in;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (run_cmp) begin
      logic [NP-1:0] ed, eo, eu;
      model_pads(ed, eo, eu);
      n_chk += 5;
      if (pad_oe !== eo) begin n_fail++; $display("FAIL R3 R4 R5 pad_oe act=%h exp=%h", pad_oe, eo); end
      if (pad_do !== ed) begin n_fail++; $display("FAIL R6 pad_do act=%h exp=%h", pad_do, ed); end
      if (pad_pu !== eu) begin n_fail++; $display("FAIL R7 pad_pu act=%h exp=%h", pad_pu, eu); end
      if (core_in !== (m_s2 ^ inv_vec())) begin
        n_fail++; $display("FAIL R8 core_in act=%h exp=%h", core_in, m_s2 ^ inv_vec());
      end
      if (reg_rdata !== m_rd) begin n_fail++; $display("FAIL R1 reg_rdata act=%h exp=%h", reg_rdata, m_rd); end
    end
  end

  // ---------------- helpers ----------------
  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = 6'(a); reg_wdata = d;
    tick();
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a);
    reg_re = 1'b1; reg_addr = 6'(a);
    tick();
    reg_re = 1'b0;
  endtask

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] word_with(input int lane, input logic [7:0] b);
    logic [31:0] w;
    w = 32'h18181818;
    w[8*lane +: 8] = b;
    return w;
  endfunction

  // watchdog
  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [NP-1:0] lockmask;
    lockmask = '0;
    for (int p = 0; p < NP; p++) if (is_locked(p)) lockmask[p] = 1'b1;

    // R2: reset state
    repeat (3) tick();
    chk("R2 reset pad_oe", 128'(pad_oe), 128'(0));
    chk("R2 reset pad_do", 128'(pad_do), 128'(0));
    chk("R2 reset pad_pu", 128'(pad_pu), {20'h0, {NP{1'b1}}});
    chk("R2 reset rdata", 128'(reg_rdata), 128'(0));
    rst_n = 1'b1;
    run_cmp = 1'b1;
    rd(0);
    chk("R2 R1 reset cfg word", 128'(reg_rdata), 128'(32'h18181818));
    rd(35);
    chk("R2 reset gpio data", 128'(reg_rdata), 128'(0));

    // distinct peripheral sources: f0 do1 oe1, f1 do0 oe1, f2 do1 oe0, alt do1 oe1
    fn_do = {{NP{1'b1}}, {NP{1'b0}}, {NP{1'b1}}};
    fn_oe = {{NP{1'b0}}, {NP{1'b1}}, {NP{1'b1}}};
    alt_do = '1; alt_oe = '1;

    // R3 R4 R5: every select on low pin 5 (word 1 lane 1) and high pin 50 (word 12 lane 2)
    for (int fs = 0; fs < 8; fs++) begin
      logic [7:0] b;
      logic e_do_lo, e_oe_lo, e_do_hi, e_oe_hi;
      b = 8'((fs << 3) | 4);
      case (fs)
        0: begin e_do_lo = 1; e_oe_lo = 1; end
        1: begin e_do_lo = 0; e_oe_lo = 1; end
        2: begin e_do_lo = 1; e_oe_lo = 0; end
        3: begin e_do_lo = 0; e_oe_lo = 1; end
        4: begin e_do_lo = 1; e_oe_lo = 1; end
        default: begin e_do_lo = 0; e_oe_lo = 0; end
      endcase
      e_do_hi = (fs == 4) ? 1'b0 : e_do_lo;
      e_oe_hi = (fs == 4) ? 1'b0 : e_oe_lo;
      wr(1, word_with(1, b));
      wr(12, word_with(2, b));
      chk($sformatf("R3 R4 R5 sel=%0d low pin oe", fs), 128'(pad_oe[5]), 128'(e_oe_lo));
      chk($sformatf("R3 R4 R5 sel=%0d low pin do", fs), 128'(pad_do[5]), 128'(e_do_lo));
      chk($sformatf("R3 R4 R5 sel=%0d high pin oe", fs), 128'(pad_oe[50]), 128'(e_oe_hi));
      chk($sformatf("R3 R4 R5 sel=%0d high pin do", fs), 128'(pad_do[50]), 128'(e_do_hi));
      rd(12);
      chk($sformatf("R1 R5 sel=%0d readback", fs), 128'(reg_rdata), 128'(word_with(2, b)));
    end

    // R4: GPIO mode with data register, direction input
    wr(1, word_with(1, 8'h1C));
    wr(32, 32'h0000_0020);
    chk("R4 gpio data drives pad", 128'(pad_do[5]), 128'(1));
    wr(1, word_with(1, 8'h18));
    chk("R4 direction 0 is input", 128'(pad_oe[5]), 128'(0));

    // R6: inversion in GPIO mode and peripheral mode, and on the input path
    wr(1, word_with(1, 8'h1E));
    chk("R6 inverted gpio out", 128'(pad_do[5]), 128'(0));
    wr(32, 32'h0);
    chk("R6 inverted gpio out low", 128'(pad_do[5]), 128'(1));
    wr(1, word_with(1, 8'h02));
    chk("R6 inverted function 0 out", 128'(pad_do[5]), 128'(0));
    pad_in[5] = 1'b1;
    tick();
    chk("R8 one edge is not enough", 128'(core_in[5]), 128'(1));
    tick();
    chk("R6 R8 inverted core_in", 128'(core_in[5]), 128'(0));
    rd(40);
    chk("R6 R8 inverted input word", 128'(reg_rdata[5]), 128'(0));

    // R7: pull-up disable on every pin, locked pins stay on
    for (int k = 0; k < 27; k++) wr(k, 32'h01010101);
    chk("R7 pull-ups follow lock mask", 128'(pad_pu), 128'(lockmask));
    rd(26);
    chk("R7 R1 pud readback", 128'(reg_rdata), 128'(32'h01010101));

    // R8: input words after two flops
    pad_in = {12'h5A3, 32'hDEADBEEF, 32'h01234567, 32'h89ABCDEF};
    tick(); tick();
    rd(40); chk("R8 input word 0", 128'(reg_rdata), 128'(32'h89ABCDEF));
    rd(41); chk("R8 input word 1", 128'(reg_rdata), 128'(32'h01234567));
    rd(43); chk("R8 input word 3", 128'(reg_rdata), 128'(32'h000005A3));

    // R1 R5: reserved bits dropped, select 7 leaves pins undriven
    wr(0, 32'hFFFFFFFF);
    rd(0);
    chk("R1 reserved bits read 0", 128'(reg_rdata), 128'(32'h3F3F3F3F));
    chk("R5 select 7 undriven", 128'(pad_oe[3:0]), 128'(0));

    // R9: ignored writes
    wr(41, 32'h0);
    rd(41); chk("R9 input word ignores write", 128'(reg_rdata), 128'(32'h01234567));
    wr(50, 32'hFFFFFFFF);
    rd(50); chk("R9 unmapped reads 0", 128'(reg_rdata), 128'(0));
    chk("R9 unmapped write leaves pads", 128'(pad_oe[3:0]), 128'(0));

    // random phase: model compares every cycle
    for (int c = 0; c < 600; c++) begin
      for (int i = 0; i < 3*NP; i++) begin
        fn_do[i] = 1'($urandom_range(0, 1));
        fn_oe[i] = 1'($urandom_range(0, 1));
      end
      alt_do = 16'($urandom); alt_oe = 16'($urandom);
      for (int i = 0; i < NP; i++) pad_in[i] = 1'($urandom_range(0, 1));
      reg_we = 1'($urandom_range(0, 1));
      reg_re = 1'($urandom_range(0, 1));
      reg_addr = 6'($urandom_range(0, 63));
      reg_wdata = $urandom;
      tick();
    end
    reg_we = 1'b0; reg_re = 1'b0;
    tick(); tick();

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule